// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is a general-purpose register file that keeps four complete register banks. A 2-bit bank-select field picks which bank the pipeline sees. The pipeline gets three combinational read ports and one write port, and all four ports act on the selected bank only.

Trap handling changes the bank-select field and moves no data. An interrupt moves execution onto bank 3, which is kept for interrupt handlers. A system call moves execution onto bank 2, which is kept for system-call handlers. Banks 0 and 1 hold ordinary user tasks. On entry, the bank that was active is stored in a saved-bank register. A return writes that value back into the bank-select field in one cycle, so leaving a handler is as quick as entering it.

Privileged code runs in bank 2 or 3. It can write the bank-select field directly. It can also move a single register between the active bank and any other bank, in either direction.

Top module: `bankreg_top`

## Requirements
- R1: Reset sets every register of every bank to zero, sets the active bank to 0, clears the saved bank, and clears both error flags.
- R2: Each of the three read ports returns the selected register of the active bank combinationally. A write lands in the active bank at the clock edge. A value written in one bank is not visible in any other bank.
- R3: When an interrupt is taken from bank 0, 1 or 2, the active bank is 3 on the next cycle, and the saved bank holds the bank that was active before.
- R4: When a system call is taken from bank 0, 1 or 2, the active bank is 2 on the next cycle, and the saved bank holds the bank that was active before.
- R5: A return sets the active bank to the value of the saved bank on the next cycle.
- R6: An interrupt or a system call taken while bank 3 is active changes neither the active bank nor the saved bank. It pulses the nested-trap flag for one cycle.
- R7: In bank 2 or 3, a direct bank-select write takes effect on the next cycle. In bank 0 or 1 it is ignored, and the illegal-access flag pulses for one cycle.
- R8: An inbound cross move (direction bit 0) copies register src of the named bank into register dst of the active bank.
- R9: An outbound cross move (direction bit 1) copies register src of the active bank into register dst of the named bank.
- R10: A cross move is ignored, and the illegal-access flag pulses, when it is issued from bank 0 or 1 or when it names the active bank.
- R11: When a pipeline write and a read hit the same register in the same cycle, the read returns the new value. A cross-move write is not forwarded to the read ports. If a pipeline write and an inbound cross move target the same register, the pipeline write is kept.
- R12: When several control events arrive in the same cycle, they take effect in this order: interrupt first, then system call, then return, then direct bank write. Register writes and cross moves always use the bank that was active before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_idx_a | input | AW | Read port A register index |
| rd_idx_b | input | AW | Read port B register index |
| rd_idx_c | input | AW | Read port C register index |
| rd_data_a | output | DW | Read port A data |
| rd_data_b | output | DW | Read port B data |
| rd_data_c | output | DW | Read port C data |
| wr_en | input | 1 | Pipeline write enable |
| wr_idx | input | AW | Pipeline write index |
| wr_data | input | DW | Pipeline write data |
| irq_take | input | 1 | Interrupt entry |
| sys_take | input | 1 | System-call entry |
| ret_take | input | 1 | Handler return |
| bank_wr | input | 1 | Direct bank-select write |
| bank_wr_val | input | 2 | Value for direct bank write |
| xmv_en | input | 1 | Cross-bank move request |
| xmv_dir | input | 1 | 0 = into active bank, 1 = out of active bank |
| xmv_bank | input | 2 | Named non-active bank |
| xmv_src | input | AW | Source register index |
| xmv_dst | input | AW | Destination register index |
| bank_sel | output | 2 | Active bank |
| bank_saved | output | 2 | Saved previous bank |
| nest_err | output | 1 | Nested-trap pulse |
| illeg_err | output | 1 | Illegal-access pulse |

## Verification
The bench builds the block with 8 registers of 16 bits per bank. With so few registers, random indices often land on the same register. This makes read-after-write forwarding, a pipeline write and a cross move hitting the same target, and cross moves between every pair of banks occur often. The short data width keeps readback mismatches easy to read. Random trap, return and bank-write events move through all four banks. This brings nested traps in bank 3 and refused privileged operations from user banks within reach.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
    localparam int NBANK = 4;
    localparam logic [1:0] BANK_SYS = 2'd2;
    localparam logic [1:0] BANK_IRQ = 2'd3;

    typedef struct packed {
        logic [1:0] bank;
        logic [1:0] saved;
        logic       nest_err;
        logic       illeg_err;
    } ctl_state_t;
endpackage

// File: rtl/bankreg_ctrl.sv
module bankreg_ctrl
    import bankreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_take,
    input  logic       sys_take,
    input  logic       ret_take,
    input  logic       bank_wr,
    input  logic [1:0] bank_wr_val,
    input  logic       xmv_en,
    input  logic [1:0] xmv_bank,
    output logic       xmv_ok,
    output logic [1:0] bank_q,
    output logic [1:0] saved_q,
    output logic       nest_err_q,
    output logic       illeg_err_q
);
    ctl_state_t st_d, st_q;
    logic priv;
    logic in_irq;

    always_comb begin
        priv   = st_q.bank[1];
        in_irq = (st_q.bank == BANK_IRQ);
        xmv_ok = xmv_en && priv && (xmv_bank != st_q.bank);

        st_d           = st_q;
        st_d.nest_err  = 1'b0;
        st_d.illeg_err = xmv_en && !xmv_ok;

        if (irq_take) begin
            if (in_irq) begin
                st_d.nest_err = 1'b1;
            end else begin
                st_d.saved = st_q.bank;
                st_d.bank  = BANK_IRQ;
            end
        end else if (sys_take) begin
            if (in_irq) begin
                st_d.nest_err = 1'b1;
            end else begin
                st_d.saved = st_q.bank;
                st_d.bank  = BANK_SYS;
            end
        end else if (ret_take) begin
            st_d.bank = st_q.saved;
        end else if (bank_wr) begin
            if (priv) begin
                st_d.bank = bank_wr_val;
            end else begin
                st_d.illeg_err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank_q      = st_q.bank;
    assign saved_q     = st_q.saved;
    assign nest_err_q  = st_q.nest_err;
    assign illeg_err_q = st_q.illeg_err;

    p_irq_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && bank_q != BANK_IRQ) |=> (bank_q == BANK_IRQ && saved_q == $past(bank_q)));

    p_sys_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_take && sys_take && bank_q != BANK_IRQ) |=> (bank_q == BANK_SYS && saved_q == $past(bank_q)));

    p_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_take && !irq_take && !sys_take) |=> (bank_q == $past(saved_q)));

    p_nested_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_take || sys_take) && bank_q == BANK_IRQ) |=> ($stable(bank_q) && $stable(saved_q) && nest_err_q));

    p_user_bankwr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_wr && !irq_take && !sys_take && !ret_take && !bank_q[1]) |=> ($stable(bank_q) && illeg_err_q));

    p_bad_xmv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xmv_en && (!bank_q[1] || xmv_bank == bank_q)) |=> illeg_err_q);
endmodule

// File: rtl/bankreg_rdport.sv
module bankreg_rdport #(
    parameter int DW = 64,
    parameter int AW = 5,
    parameter int NSLOT = 128
) (
    input  logic [DW-1:0] mem     [NSLOT],
    input  logic [1:0]    bank,
    input  logic [AW-1:0] rd_idx,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    logic [AW+1:0] slot;

    always_comb begin
        slot = {bank, rd_idx};
        if (wr_en && wr_idx == rd_idx) begin
            rd_data = wr_data;
        end else begin
            rd_data = mem[slot];
        end
    end
endmodule

// File: rtl/bankreg_array.sv
module bankreg_array
    import bankreg_pkg::*;
#(
    parameter int NREG = 32,
    parameter int DW = 64,
    localparam int AW = $clog2(NREG),
    localparam int NSLOT = NBANK * NREG,
    localparam int NRD = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bank,
    input  logic [NRD*AW-1:0] rd_idx,
    output logic [NRD*DW-1:0] rd_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [DW-1:0]     wr_data,
    input  logic              xmv_ok,
    input  logic              xmv_dir,
    input  logic [1:0]        xmv_bank,
    input  logic [AW-1:0]     xmv_src,
    input  logic [AW-1:0]     xmv_dst
);
    logic [DW-1:0] mem_d [NSLOT];
    logic [DW-1:0] mem_q [NSLOT];
    logic [DW-1:0] xval;
    logic [AW+1:0] xsrc_slot;
    logic [AW+1:0] xdst_slot;

    always_comb begin
        xsrc_slot = xmv_dir ? {bank, xmv_src} : {xmv_bank, xmv_src};
        xdst_slot = xmv_dir ? {xmv_bank, xmv_dst} : {bank, xmv_dst};
        xval      = mem_q[xsrc_slot];
        for (int i = 0; i < NSLOT; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (xmv_ok) begin
            mem_d[xdst_slot] = xval;
        end
        if (wr_en) begin
            mem_d[{bank, wr_idx}] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        bankreg_rdport #(.DW(DW), .AW(AW), .NSLOT(NSLOT)) u_rd (
            .mem     (mem_q),
            .bank    (bank),
            .rd_idx  (rd_idx[p*AW +: AW]),
            .wr_en   (wr_en),
            .wr_idx  (wr_idx),
            .wr_data (wr_data),
            .rd_data (rd_data[p*DW +: DW])
        );
    end

    p_outbound_keeps_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xmv_ok && xmv_dir && !wr_en) |=> (mem_q[{$past(bank), $past(xmv_src)}] == $past(xval)));

    p_inbound_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xmv_ok && !xmv_dir && !(wr_en && wr_idx == xmv_dst)) |=> (mem_q[{$past(bank), $past(xmv_dst)}] == $past(mem_q[{xmv_bank, xmv_src}])));
endmodule

// File: rtl/bankreg_top.sv
module bankreg_top
    import bankreg_pkg::*;
#(
    parameter int NREG = 32,
    parameter int DW = 64,
    localparam int AW = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_idx_a,
    input  logic [AW-1:0] rd_idx_b,
    input  logic [AW-1:0] rd_idx_c,
    output logic [DW-1:0] rd_data_a,
    output logic [DW-1:0] rd_data_b,
    output logic [DW-1:0] rd_data_c,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          irq_take,
    input  logic          sys_take,
    input  logic          ret_take,
    input  logic          bank_wr,
    input  logic [1:0]    bank_wr_val,
    input  logic          xmv_en,
    input  logic          xmv_dir,
    input  logic [1:0]    xmv_bank,
    input  logic [AW-1:0] xmv_src,
    input  logic [AW-1:0] xmv_dst,
    output logic [1:0]    bank_sel,
    output logic [1:0]    bank_saved,
    output logic          nest_err,
    output logic          illeg_err
);
    logic          xmv_ok;
    logic [3*DW-1:0] rd_bus;

    bankreg_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_take    (irq_take),
        .sys_take    (sys_take),
        .ret_take    (ret_take),
        .bank_wr     (bank_wr),
        .bank_wr_val (bank_wr_val),
        .xmv_en      (xmv_en),
        .xmv_bank    (xmv_bank),
        .xmv_ok      (xmv_ok),
        .bank_q      (bank_sel),
        .saved_q     (bank_saved),
        .nest_err_q  (nest_err),
        .illeg_err_q (illeg_err)
    );

    bankreg_array #(.NREG(NREG), .DW(DW)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank     (bank_sel),
        .rd_idx   ({rd_idx_c, rd_idx_b, rd_idx_a}),
        .rd_data  (rd_bus),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .xmv_ok   (xmv_ok),
        .xmv_dir  (xmv_dir),
        .xmv_bank (xmv_bank),
        .xmv_src  (xmv_src),
        .xmv_dst  (xmv_dst)
    );

    assign rd_data_a = rd_bus[0*DW +: DW];
    assign rd_data_b = rd_bus[1*DW +: DW];
    assign rd_data_c = rd_bus[2*DW +: DW];
endmodule

// File: tb/sim_bankreg_top.sv
module sim_bankreg_top;
    localparam int PERIOD = 10;
    localparam int NR = 8;
    localparam int DW = 16;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] ra = '0, rb = '0, rc = '0;
    logic [DW-1:0] da, db, dc;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic irq = 1'b0, sys = 1'b0, ret = 1'b0, bwr = 1'b0;
    logic [1:0] bval = '0;
    logic xen = 1'b0, xdir = 1'b0;
    logic [1:0] xb = '0;
    logic [AW-1:0] xs = '0, xd = '0;
    logic [1:0] bank_sel, bank_saved;
    logic nest_err, illeg_err;

    logic [DW-1:0] model [4][NR];
    logic [1:0] m_bank, m_saved;
    logic m_nest, m_ill;
    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    bankreg_top #(.NREG(NR), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_idx_a(ra), .rd_idx_b(rb), .rd_idx_c(rc),
        .rd_data_a(da), .rd_data_b(db), .rd_data_c(dc),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .irq_take(irq), .sys_take(sys), .ret_take(ret),
        .bank_wr(bwr), .bank_wr_val(bval),
        .xmv_en(xen), .xmv_dir(xdir), .xmv_bank(xb), .xmv_src(xs), .xmv_dst(xd),
        .bank_sel(bank_sel), .bank_saved(bank_saved),
        .nest_err(nest_err), .illeg_err(illeg_err)
    );

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] idx);
        if (wr_en && wr_idx == idx) return wr_data;
        return model[m_bank][idx];
    endfunction

    task automatic clear_in();
        wr_en = 0; irq = 0; sys = 0; ret = 0; bwr = 0; xen = 0;
    endtask

    // one cycle: check reads, advance model, check state
    task automatic step();
        logic [1:0] ob;
        logic priv;
        logic [DW-1:0] xv;
        @(negedge clk);
        #1;
        chk("R2/R11 port a", da, exp_rd(ra));
        chk("R2/R11 port b", db, exp_rd(rb));
        chk("R2/R11 port c", dc, exp_rd(rc));
        ob = m_bank;
        priv = ob[1];
        m_nest = 0;
        m_ill = 0;
        if (xen) begin
            if (!priv || xb == ob) begin
                m_ill = 1;
            end else if (!xdir) begin
                xv = model[xb][xs];
                model[ob][xd] = xv;
            end else begin
                xv = model[ob][xs];
                model[xb][xd] = xv;
            end
        end
        if (wr_en) model[ob][wr_idx] = wr_data;
        if (irq) begin
            if (ob == 2'd3) m_nest = 1;
            else begin m_saved = ob; m_bank = 2'd3; end
        end else if (sys) begin
            if (ob == 2'd3) m_nest = 1;
            else begin m_saved = ob; m_bank = 2'd2; end
        end else if (ret) begin
            m_bank = m_saved;
        end else if (bwr) begin
            if (priv) m_bank = bval;
            else m_ill = 1;
        end
        @(posedge clk);
        #1;
        chk("R3/R4/R5/R7/R12 bank", DW'(bank_sel), DW'(m_bank));
        chk("R3/R4/R6 saved", DW'(bank_saved), DW'(m_saved));
        chk("R6 nest flag", DW'(nest_err), DW'(m_nest));
        chk("R7/R10 illegal flag", DW'(illeg_err), DW'(m_ill));
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int b = 0; b < 4; b++)
            for (int r = 0; r < NR; r++) model[b][r] = '0;
        m_bank = 0; m_saved = 0; m_nest = 0; m_ill = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        chk("R1 bank", DW'(bank_sel), '0);
        chk("R1 saved", DW'(bank_saved), '0);
        chk("R1 flags", DW'({nest_err, illeg_err}), '0);
        for (int r = 0; r < NR; r++) begin
            ra = AW'(r);
            #1;
            chk("R1 reg zero", da, '0);
        end

        // R2: write in bank 0, read back
        clear_in(); wr_en = 1; wr_idx = 3'd5; wr_data = 16'hA5A5; ra = 3'd5; step();
        clear_in(); ra = 3'd5; rb = 3'd4; step();
        // R3: irq from bank 0; R2 bank 3 reg5 reads zero
        clear_in(); irq = 1; step();
        clear_in(); ra = 3'd5; step();
        // R8: pull bank0 r5 into bank3 r1
        clear_in(); xen = 1; xdir = 0; xb = 2'd0; xs = 3'd5; xd = 3'd1; ra = 3'd1; step();
        clear_in(); ra = 3'd1; step();
        // R9: push bank3 r1 to bank1 r7
        clear_in(); xen = 1; xdir = 1; xb = 2'd1; xs = 3'd1; xd = 3'd7; step();
        // R10: cross move naming active bank
        clear_in(); xen = 1; xdir = 1; xb = 2'd3; xs = 3'd1; xd = 3'd2; step();
        // R6: nested irq and sys in bank 3
        clear_in(); irq = 1; step();
        clear_in(); sys = 1; step();
        // R11: inbound move and pipeline write on same target; write wins, no forward of move
        clear_in(); xen = 1; xdir = 0; xb = 2'd0; xs = 3'd5; xd = 3'd6;
        wr_en = 1; wr_idx = 3'd6; wr_data = 16'h1234; ra = 3'd6; step();
        clear_in(); xen = 1; xdir = 0; xb = 2'd0; xs = 3'd5; xd = 3'd2; ra = 3'd2; step();
        // R5: return to bank 0
        clear_in(); ret = 1; step();
        // R7: bank write ignored in user bank; R10 move from user bank
        clear_in(); bwr = 1; bval = 2'd2; step();
        clear_in(); xen = 1; xb = 2'd1; step();
        // R4: syscall, R3: irq from 2, R5 back to 2
        clear_in(); sys = 1; step();
        clear_in(); irq = 1; step();
        clear_in(); ret = 1; step();
        // R7: bank write from bank 2 to bank 1, read bank 1 r7
        clear_in(); bwr = 1; bval = 2'd1; step();
        clear_in(); ra = 3'd7; step();
        // R12: all events together, irq wins
        clear_in(); irq = 1; sys = 1; ret = 1; bwr = 1; bval = 2'd0; step();
        clear_in(); sys = 1; ret = 1; step();
        clear_in(); ret = 1; bwr = 1; bval = 2'd2; step();

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            clear_in();
            ra = AW'($urandom); rb = AW'($urandom); rc = AW'($urandom);
            wr_en = ($urandom % 2) == 0;
            wr_idx = AW'($urandom);
            wr_data = DW'($urandom);
            if (($urandom % 4) == 0) ra = wr_idx;
            irq = ($urandom % 12) == 0;
            sys = ($urandom % 12) == 0;
            ret = ($urandom % 8) == 0;
            bwr = ($urandom % 10) == 0;
            bval = 2'($urandom);
            xen = ($urandom % 4) == 0;
            xdir = 1'($urandom);
            xb = 2'($urandom);
            xs = AW'($urandom);
            xd = AW'($urandom);
            step();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule